// File: doc/BRIEF.md
# Reloading interval timer with core routing

The block is a free-running interval timer for a multi-core cluster. Software programs a 28-bit interval and turns the timer on. The count then drops by one on every pulse of a reference tick input, which is 38.4 MHz in the intended system. When an interval runs out, the timer raises a sticky pending flag and starts the next interval of the same length straight away, with no software action.

A separate acknowledge register drops the flag and can restart the running interval from its full length. A small routing register sends the pending flag to one core. It picks the core and also whether the request is an IRQ or an FIQ. The request reaches that core only while interrupt delivery is enabled.

All registers sit on a simple 32-bit write-strobe bus with a combinational read path. The reference clock source and its prescaler are outside the block.

Top module: `lcl_interval_timer`

## Requirements
- R1: After reset, the control register (offset 0x34) and the routing register (offset 0x24) read 0, the timer is stopped and no IRQ or FIQ request is asserted.
- R2: A control write with bit 28 (run) set and a non-zero interval N in bits [27:0] starts an interval that expires on the Nth following tick pulse and not before. Expiry sets the flag, which reads as control bit 31. N = 1 expires on every tick.
- R3: At expiry the next interval of the same length N starts at once, so expiries repeat every N ticks without any software access.
- R4: A control write with bit 28 clear stops the count: further ticks neither set the flag nor advance the timer. A write with bit 28 set and an interval of 0 leaves the timer stopped.
- R5: A write to the acknowledge register (offset 0x38) with bit 31 set clears the flag. The acknowledge register reads 0.
- R6: An acknowledge write with bit 30 set restarts the interval from its full length while the timer runs. While the timer is stopped, the same write has no effect and does not start it.
- R7: The routing register keeps bits [2:0] and drops the rest. Bits [1:0] select the core. Bit 2 = 0 sends the request on irq_req and bit 2 = 1 sends it on fiq_req. At most one request line is asserted at a time.
- R8: A request is asserted only while both the flag and control bit 29 (interrupt enable) are set.
- R9: When a flag-clearing acknowledge and an expiry fall in the same cycle, the flag stays set.
- R10: Control bit 31 is read-only: writing it neither sets nor clears the flag.
- R11: The control register reads back bit 30 (reload option), bit 29, bit 28 and the interval bits [27:0] as last written, with the flag in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle reference tick pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_req | output | 4 | Per-core IRQ request |
| fiq_req | output | 4 | Per-core FIQ request |

## Verification
The bench aims at off-by-one expiry. It reads the flag one tick before and exactly on the programmed count, with N = 1 as the shortest case; a counter that expired on zero instead of one would be late by a tick. It drives an acknowledge-clear in the very cycle of an expiry, where a design that gave the clear priority would lose an interrupt. It also issues a restart while the timer is stopped and an enable with interval 0, where a careless design would start counting.

All eight routing codes are walked with junk in the upper write bits, which would expose swapped IRQ/FIQ selection or unmasked routing bits.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_ACK   = 2'd2,
      SEL_ROUTE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic reload;
      logic int_en;
      logic run_en;
   } ctrl_bits_t;
endpackage

// File: rtl/ltmr_regs.sv
module ltmr_regs
   import ltmr_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 28,
   parameter int RT_W    = 3,
   parameter logic [ADDR_W-1:0] A_CTRL  = 8'h34,
   parameter logic [ADDR_W-1:0] A_ACK   = 8'h38,
   parameter logic [ADDR_W-1:0] A_ROUTE = 8'h24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              expire,
   output logic              run_en,
   output logic              int_en,
   output logic [CNT_W-1:0]  interval,
   output logic [RT_W-1:0]   route,
   output logic              flag,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic              cfg_wr
);
   localparam int EN_B  = CNT_W;
   localparam int IE_B  = CNT_W + 1;
   localparam int RL_B  = CNT_W + 2;
   localparam int FL_B  = CNT_W + 3;

   if (DATA_W < CNT_W + 4) begin : g_bad_width
      $error("ltmr_regs: DATA_W too small for control fields");
   end
   if (RT_W > DATA_W) begin : g_bad_route
      $error("ltmr_regs: RT_W exceeds DATA_W");
   end

   reg_sel_e   sel;
   ctrl_bits_t ctrl_q;
   logic       wr_ctrl, wr_ack, wr_route;
   logic       new_nonzero, cur_nonzero;

   always_comb begin
      if (bus_addr == A_CTRL)       sel = SEL_CTRL;
      else if (bus_addr == A_ACK)   sel = SEL_ACK;
      else if (bus_addr == A_ROUTE) sel = SEL_ROUTE;
      else                          sel = SEL_NONE;
   end

   assign wr_ctrl  = bus_wr && (sel == SEL_CTRL);
   assign wr_ack   = bus_wr && (sel == SEL_ACK);
   assign wr_route = bus_wr && (sel == SEL_ROUTE);
   assign cfg_wr   = wr_ctrl;

   assign new_nonzero = |bus_wdata[CNT_W-1:0];
   assign cur_nonzero = |interval;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         interval <= '0;
         route    <= '0;
         flag     <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.reload <= bus_wdata[RL_B];
            ctrl_q.int_en <= bus_wdata[IE_B];
            ctrl_q.run_en <= bus_wdata[EN_B];
            interval      <= bus_wdata[CNT_W-1:0];
         end
         if (wr_route) begin
            route <= bus_wdata[RT_W-1:0];
         end
         if (expire) begin
            flag <= 1'b1;
         end else if (wr_ack && bus_wdata[FL_B]) begin
            flag <= 1'b0;
         end
      end
   end

   assign run_en = ctrl_q.run_en;
   assign int_en = ctrl_q.int_en;

   always_comb begin
      load     = 1'b0;
      load_val = interval;
      if (wr_ctrl) begin
         load     = bus_wdata[EN_B] && new_nonzero;
         load_val = bus_wdata[CNT_W-1:0];
      end else if (wr_ack && bus_wdata[RL_B]) begin
         load     = ctrl_q.run_en && cur_nonzero;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_CTRL: begin
            bus_rdata[CNT_W-1:0] = interval;
            bus_rdata[EN_B]      = ctrl_q.run_en;
            bus_rdata[IE_B]      = ctrl_q.int_en;
            bus_rdata[RL_B]      = ctrl_q.reload;
            bus_rdata[FL_B]      = flag;
         end
         SEL_ROUTE: bus_rdata[RT_W-1:0] = route;
         default:   bus_rdata = '0;
      endcase
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag); // R9
   AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && bus_wdata[FL_B] && !expire) |=> !flag); // R5
   AST_FLAG_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !expire && !wr_ack) |=> (flag == $past(flag))); // R10
endmodule

// File: rtl/ltmr_counter.sv
module ltmr_counter #(
   parameter int CNT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             hold,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] interval,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("ltmr_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic             last;

   assign last   = (cnt == ONE);
   assign expire = tick && run && !hold && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (tick && run && !hold) begin
         cnt <= last ? interval : cnt - ONE;
      end
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt != '0 && cnt <= interval)); // R2
   AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt == $past(interval))); // R3
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(cnt)); // R4
endmodule

// File: rtl/ltmr_route.sv
module ltmr_route #(
   parameter int N_CORES = 4,
   parameter int RT_W    = 3,
   parameter bit OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flag,
   input  logic               int_en,
   input  logic [RT_W-1:0]    route,
   output logic [N_CORES-1:0] irq_req,
   output logic [N_CORES-1:0] fiq_req
);
   localparam int CORE_W = $clog2(N_CORES);

   if (N_CORES < 2 || (1 << CORE_W) != N_CORES) begin : g_bad_cores
      $error("ltmr_route: N_CORES must be a power of two, at least 2");
   end
   if (RT_W != CORE_W + 1) begin : g_bad_rt
      $error("ltmr_route: RT_W must be CORE_W + 1");
   end

   logic               pend;
   logic               to_fiq;
   logic [N_CORES-1:0] irq_n, fiq_n;

   assign pend   = flag && int_en;
   assign to_fiq = route[CORE_W];

   for (genvar c = 0; c < N_CORES; c++) begin : g_core
      logic hit;
      assign hit      = (route[CORE_W-1:0] == CORE_W'(c));
      assign irq_n[c] = pend && hit && !to_fiq;
      assign fiq_n[c] = pend && hit && to_fiq;
   end

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq_req <= '0;
            fiq_req <= '0;
         end else begin
            irq_req <= irq_n;
            fiq_req <= fiq_n;
         end
      end
   end else begin : g_comb_out
      assign irq_req = irq_n;
      assign fiq_req = fiq_n;
      AST_REQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
         (|{irq_req, fiq_req}) |-> (flag && int_en)); // R8
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_req, fiq_req})); // R7
endmodule

// File: rtl/lcl_interval_timer.sv
module lcl_interval_timer #(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 28,
   parameter int N_CORES = 4,
   parameter bit OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [N_CORES-1:0] irq_req,
   output logic [N_CORES-1:0] fiq_req
);
   localparam int RT_W = $clog2(N_CORES) + 1;

   logic             run_en, int_en, flag, load, cfg_wr, expire, run;
   logic [CNT_W-1:0] interval, load_val;
   logic [RT_W-1:0]  route;

   ltmr_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .RT_W   (RT_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .expire    (expire),
      .run_en    (run_en),
      .int_en    (int_en),
      .interval  (interval),
      .route     (route),
      .flag      (flag),
      .load      (load),
      .load_val  (load_val),
      .cfg_wr    (cfg_wr)
   );

   assign run = run_en && (interval != '0);

   ltmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .run      (run),
      .hold     (cfg_wr),
      .load     (load),
      .load_val (load_val),
      .interval (interval),
      .expire   (expire)
   );

   ltmr_route #(
      .N_CORES (N_CORES),
      .RT_W    (RT_W),
      .OUT_REG (OUT_REG)
   ) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .flag    (flag),
      .int_en  (int_en),
      .route   (route),
      .irq_req (irq_req),
      .fiq_req (fiq_req)
   );
endmodule

// File: tb/lcl_interval_timer_tb.sv
module lcl_interval_timer_tb;
   localparam logic [7:0] A_CTRL  = 8'h34;
   localparam logic [7:0] A_ACK   = 8'h38;
   localparam logic [7:0] A_ROUTE = 8'h24;
   localparam logic [31:0] F_FLAG = 32'h8000_0000;
   localparam logic [31:0] F_RLD  = 32'h4000_0000;
   localparam logic [31:0] F_IE   = 32'h2000_0000;
   localparam logic [31:0] F_EN   = 32'h1000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  irq_req, fiq_req;
   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   lcl_interval_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_req(irq_req), .fiq_req(fiq_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
      bus_addr = '0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic chk_flag(input string tag, input logic exp);
      logic [31:0] v;
      rd(A_CTRL, v);
      chk(tag, {31'd0, v[31]}, {31'd0, exp});
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_CTRL, v);  chk("R1 control after reset", v, 32'h0);
      rd(A_ROUTE, v); chk("R1 route after reset", v, 32'h0);
      chk("R1 requests after reset", {24'd0, fiq_req, irq_req}, 32'h0);
      ticks(3);
      chk_flag("R1 no expiry while stopped", 1'b0);
   endtask

   task automatic t_interval();
      logic [31:0] v;
      wr(A_ROUTE, 32'h0);
      wr(A_CTRL, F_EN | F_IE | 32'd5);
      ticks(4);
      chk_flag("R2 no flag one tick early", 1'b0);
      chk("R8 no request before expiry", {28'd0, irq_req}, 32'h0);
      ticks(1);
      chk_flag("R2 flag on fifth tick", 1'b1);
      chk("R8 irq to core0", {28'd0, irq_req}, 32'h1);
      rd(A_CTRL, v);
      chk("R11 control readback", v, F_FLAG | F_IE | F_EN | 32'd5);
      wr(A_CTRL, F_RLD | F_EN | F_IE | 32'h0ABC_DEF5);
      rd(A_CTRL, v);
      chk("R11 reload bit and full interval", v, F_FLAG | F_RLD | F_IE | F_EN | 32'h0ABC_DEF5);
   endtask

   task automatic t_reload();
      logic [31:0] v;
      wr(A_CTRL, F_EN | F_IE | 32'd5);
      wr(A_ACK, F_FLAG);
      chk_flag("R5 ack clears flag", 1'b0);
      rd(A_ACK, v);
      chk("R5 ack reads zero", v, 32'h0);
      ticks(4);
      chk_flag("R3 second interval not yet done", 1'b0);
      ticks(1);
      chk_flag("R2 first interval expires", 1'b1);
      wr(A_ACK, F_FLAG);
      ticks(4);
      chk_flag("R3 auto reload early check", 1'b0);
      ticks(1);
      chk_flag("R3 auto reload expiry", 1'b1);
   endtask

   task automatic t_inten();
      wr(A_ACK, F_FLAG);
      wr(A_CTRL, F_FLAG | F_EN | 32'd5);
      chk_flag("R10 writing bit31 does not set flag", 1'b0);
      ticks(5);
      chk_flag("R2 expiry with interrupts off", 1'b1);
      chk("R8 no request without enable", {24'd0, fiq_req, irq_req}, 32'h0);
      wr(A_CTRL, F_EN | F_IE | 32'd5);
      chk_flag("R10 writing bit31 clear keeps flag", 1'b1);
      chk("R8 request once enabled", {28'd0, irq_req}, 32'h1);
   endtask

   task automatic t_route();
      logic [31:0] v;
      for (int r = 0; r < 8; r++) begin
         wr(A_ROUTE, 32'hFFFF_FFF8 | r);
         rd(A_ROUTE, v);
         chk("R7 route keeps three bits", v, r);
         chk("R7 irq target", {28'd0, irq_req}, (r < 4) ? (32'h1 << r) : 32'h0);
         chk("R7 fiq target", {28'd0, fiq_req}, (r >= 4) ? (32'h1 << (r - 4)) : 32'h0);
      end
      wr(A_ROUTE, 32'h0);
   endtask

   task automatic t_stop();
      wr(A_ACK, F_FLAG);
      wr(A_CTRL, F_IE | 32'd5);
      ticks(10);
      chk_flag("R4 stopped timer ignores ticks", 1'b0);
      wr(A_ACK, F_RLD);
      ticks(10);
      chk_flag("R6 restart ignored while stopped", 1'b0);
      wr(A_CTRL, F_EN | F_IE | 32'd0);
      ticks(10);
      chk_flag("R4 zero interval stays stopped", 1'b0);
   endtask

   task automatic t_restart();
      wr(A_CTRL, F_EN | F_IE | 32'd4);
      ticks(3);
      wr(A_ACK, F_RLD);
      ticks(3);
      chk_flag("R6 restart extends interval", 1'b0);
      ticks(1);
      chk_flag("R6 restart full length expiry", 1'b1);
   endtask

   task automatic t_collide();
      wr(A_CTRL, F_EN | F_IE | 32'd3);
      wr(A_ACK, F_FLAG);
      ticks(2);
      chk_flag("R9 before collision", 1'b0);
      @(negedge clk);
      tick = 1'b1; bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = F_FLAG;
      @(negedge clk);
      tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      chk_flag("R9 expiry beats clear", 1'b1);
      chk("R9 request held", {28'd0, irq_req}, 32'h1);
   endtask

   task automatic t_one();
      wr(A_CTRL, F_EN | F_IE | 32'd1);
      wr(A_ACK, F_FLAG);
      chk_flag("R2 interval one cleared", 1'b0);
      ticks(1);
      chk_flag("R2 interval one first tick", 1'b1);
      wr(A_ACK, F_FLAG);
      ticks(1);
      chk_flag("R3 interval one every tick", 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_interval();
      t_reload();
      t_inten();
      t_route();
      t_stop();
      t_restart();
      t_collide();
      t_one();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule